// File: doc/BRIEF.md
# External Interrupt Edge Flag Controller

This block turns seven external interrupt request lines into latched pending flags for an 8051-style processor core. Every request line first passes through a synchronizer. An edge detector then watches each line, and each line has its own fixed sensitivity:

- Lines 0 and 1 react to a falling edge.
- Lines 2 and 3 take the edge that software selects.
- Line 4 reacts to a rising edge.
- Lines 5 and 6 are inverted ahead of the detector, so their detector sees a rising edge when the source level falls.

A detected edge latches a pending flag. The flag vector goes straight to the core's interrupt logic.

The core clears flags 0 to 5 by pulsing the matching service-acknowledge input. Flag 6 clears only when software writes to it. Software reaches the block through two special-function registers on a simple 8-bit-address SFR bus:

- The edge-select register holds the two polarity choices.
- The request register shows the upper five flags. Software can also write it to raise or drop those flags.

Top module: `xint_flag_ctrl`

## Requirements
- R1: After reset every pending flag is 0, and reads of address 0xC8 and address 0xC0 both return 0x00. Both polarity choices are 0 (falling edge).
- R2: A change on a request input that is stable before a rising clock edge sets its flag at the third rising edge after it. The flag is still 0 after the second edge.
- R3: Line 2 takes its edge from bit 5 of register 0xC8, and line 3 takes its edge from bit 6. A value of 0 selects the falling edge and 1 selects the rising edge. The opposite transition leaves the flag at 0.
- R4: Lines 0 and 1 set only on a falling source transition. Line 4 sets only on a rising source transition.
- R5: Lines 5 and 6 set only on a falling source transition. A rising source transition on them leaves the flag at 0.
- R6: Driving irq_ack[k] high for one cycle, for k from 0 to 5, clears irq_pend[k] at that clock edge.
- R7: Flag 6 ignores every acknowledge input. It clears only through a software write of 0 to bit 5 of register 0xC0.
- R8: Register 0xC0 maps flags 6, 5, 4, 3 and 2 to bits 5, 4, 3, 2 and 1. Writing a bit loads the flag with the written value. Bits 7, 6 and 0 always read 0.
- R9: Register 0xC8 bits 7 and 4:0 read 0 and ignore writes. Writes to any address other than 0xC0 and 0xC8 change no flag and no polarity bit. Reads of such addresses return 0.
- R10: An edge that reaches a flag in the same cycle as its acknowledge or a software write of 0 leaves the flag set.
- R11: A software write to a flag in the same cycle as its acknowledge loads the written value, so the write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 7 | Raw asynchronous request lines, line k on bit k |
| irq_ack | input | 6 | Service-acknowledge pulses for lines 0 to 5, active high |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe, one cycle per write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from sfr_addr |
| irq_pend | output | 7 | Pending flags to the interrupt logic, line k on bit k |

## Verification
Some internal faults show at irq_pend on the third clock edge after the stimulus. These include a wrong synchronizer depth, a swapped polarity select, or a line inverted in error. In each case a flag rises a cycle early or late, rises on the wrong transition, or stays low.

Other faults show on irq_pend one edge after the conflicting cycle. These cover a wrong clear priority or an acknowledge routed to the wrong line. The symptom is a flag that drops or survives when it should not.

Faults in the register layout show at once on sfr_rdata, in the same cycle the address is presented. Each edge kind and each polarity setting is therefore swept on every line. Each result is checked at the exact edge where it must appear.

// File: rtl/xint_pkg.sv
package xint_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_PROG = 2'd2
   } edge_mode_e;

   localparam int XINT_LINES   = 7;
   localparam int XINT_ACKED   = 6;
   localparam int XINT_SW_BASE = 2;   // first line visible in the request register

   // fixed sensitivity of each line at the detector
   function automatic edge_mode_e line_mode(input int k);
      if (k < 2)       return EDGE_FALL;
      else if (k < 4)  return EDGE_PROG;
      else             return EDGE_RISE;
   endfunction

   // lines whose source is inverted before detection
   function automatic bit line_inverted(input int k);
      return (k == 5) || (k == 6);
   endfunction

   // lines cleared by the service acknowledge
   function automatic bit line_acked(input int k);
      return k < XINT_ACKED;
   endfunction

   // lines software can read and write
   function automatic bit line_sw(input int k);
      return k >= XINT_SW_BASE;
   endfunction

   // which polarity bit a programmable line uses
   function automatic int line_pol_idx(input int k);
      return (k == 3) ? 1 : 0;
   endfunction

   function automatic logic [XINT_LINES-1:0] inv_mask();
      logic [XINT_LINES-1:0] m;
      m = '0;
      for (int k = 0; k < XINT_LINES; k++) m[k] = line_inverted(k);
      return m;
   endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("xint_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xint_edge.sv
module xint_edge
   import xint_pkg::*;
#(
   parameter edge_mode_e MODE = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic pol_rise,
   output logic hit
);

   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   generate
      if (MODE == EDGE_PROG) begin : g_prog
         assign hit = pol_rise ? rise : fall;
      end else if (MODE == EDGE_RISE) begin : g_rise
         logic pol_unused;
         assign pol_unused = pol_rise;
         assign hit = rise;
      end else begin : g_fall
         logic pol_unused;
         assign pol_unused = pol_rise;
         assign hit = fall;
      end
   endgenerate

   AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (level != prev_q)); // R3

endmodule

// File: rtl/xint_flag.sv
module xint_flag #(
   parameter bit HAS_ACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   input  logic sw_we,
   input  logic sw_val,
   output logic flag
);

   logic ack_eff;

   generate
      if (HAS_ACK) begin : g_ack
         assign ack_eff = ack;
      end else begin : g_noack
         logic ack_unused;
         assign ack_unused = ack;
         assign ack_eff    = 1'b0;
      end
   endgenerate

   // edge beats software, software beats acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set)     flag <= 1'b1;
      else if (sw_we)   flag <= sw_val;
      else if (ack_eff) flag <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag); // R10

   AST_SW_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !set) |=> (flag == $past(sw_val))); // R11

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_ACK && ack && !set && !sw_we) |=> !flag); // R6

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !sw_we && !(HAS_ACK && ack)) |=> $stable(flag)); // R7

endmodule

// File: rtl/xint_sfr.sv
module xint_sfr #(
   parameter int             ADDR_W   = 8,
   parameter int             DATA_W   = 8,
   parameter logic [ADDR_W-1:0] POL_ADDR = 8'hC8,
   parameter logic [ADDR_W-1:0] REQ_ADDR = 8'hC0,
   parameter int             POL_LO   = 5,
   parameter int             REQ_LSB  = 1,
   parameter int             REQ_N    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [REQ_N-1:0]  req_flags,
   output logic [1:0]        pol_rise,
   output logic              req_we,
   output logic [REQ_N-1:0]  req_wval
);

   localparam logic [DATA_W-1:0] REQ_MASK = {{(DATA_W-REQ_N){1'b0}}, {REQ_N{1'b1}}} << REQ_LSB;
   localparam logic [DATA_W-1:0] POL_MASK = {{(DATA_W-2){1'b0}}, 2'b11} << POL_LO;

   logic pol_we;
   logic spare_unused;

   generate
      if (REQ_LSB + REQ_N > DATA_W) begin : g_bad_req
         $error("request field does not fit the data width");
      end
      if (POL_LO + 2 > DATA_W) begin : g_bad_pol
         $error("polarity field does not fit the data width");
      end
   endgenerate

   assign pol_we   = wr && (addr == POL_ADDR);
   assign req_we   = wr && (addr == REQ_ADDR);
   assign req_wval = wdata[REQ_LSB +: REQ_N];
   assign spare_unused = ^(wdata & ~(REQ_MASK | POL_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pol_rise <= 2'b00;
      else if (pol_we) pol_rise <= wdata[POL_LO +: 2];
   end

   always_comb begin
      rdata = '0;
      if (addr == POL_ADDR)      rdata[POL_LO +: 2]       = pol_rise;
      else if (addr == REQ_ADDR) rdata[REQ_LSB +: REQ_N] = req_flags;
   end

   AST_REQ_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REQ_ADDR) |-> ((rdata & ~REQ_MASK) == '0)); // R8

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == POL_ADDR) |=> $stable(pol_rise)); // R9

endmodule

// File: rtl/xint_flag_ctrl.sv
module xint_flag_ctrl
   import xint_pkg::*;
#(
   parameter int             NUM_LINES   = 7,
   parameter int             NUM_ACK     = 6,
   parameter int             SYNC_STAGES = 2,
   parameter int             ADDR_W      = 8,
   parameter int             DATA_W      = 8,
   parameter logic [ADDR_W-1:0] POL_ADDR = 8'hC8,
   parameter logic [ADDR_W-1:0] REQ_ADDR = 8'hC0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_src,
   input  logic [NUM_ACK-1:0]   irq_ack,
   input  logic [ADDR_W-1:0]    sfr_addr,
   input  logic                 sfr_wr,
   input  logic [DATA_W-1:0]    sfr_wdata,
   output logic [DATA_W-1:0]    sfr_rdata,
   output logic [NUM_LINES-1:0] irq_pend
);

   localparam int REQ_N   = NUM_LINES - XINT_SW_BASE;
   localparam int REQ_LSB = 1;
   localparam int L6_BIT  = REQ_LSB + (NUM_LINES - 1 - XINT_SW_BASE);

   logic [NUM_LINES-1:0] src_norm;
   logic [NUM_LINES-1:0] lvl_sync;
   logic [NUM_LINES-1:0] hit;
   logic [1:0]           pol_rise;
   logic                 req_we;
   logic [REQ_N-1:0]     req_wval;

   generate
      if (NUM_LINES != XINT_LINES) begin : g_bad_lines
         $error("line count must match the package map");
      end
      if (NUM_ACK != XINT_ACKED) begin : g_bad_ack
         $error("acknowledge count must match the package map");
      end
   endgenerate

   assign src_norm = irq_src ^ inv_mask();

   xint_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_norm),
      .q     (lvl_sync)
   );

   xint_sfr #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .POL_ADDR (POL_ADDR),
      .REQ_ADDR (REQ_ADDR),
      .POL_LO   (5),
      .REQ_LSB  (REQ_LSB),
      .REQ_N    (REQ_N)
   ) u_sfr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (sfr_addr),
      .wr        (sfr_wr),
      .wdata     (sfr_wdata),
      .rdata     (sfr_rdata),
      .req_flags (irq_pend[NUM_LINES-1:XINT_SW_BASE]),
      .pol_rise  (pol_rise),
      .req_we    (req_we),
      .req_wval  (req_wval)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         localparam edge_mode_e LMODE = line_mode(i);
         localparam bit         LACK  = line_acked(i);
         logic ack_i;
         logic we_i;
         logic val_i;

         if (LACK) begin : g_ack
            assign ack_i = irq_ack[i];
         end else begin : g_noack
            assign ack_i = 1'b0;
         end

         if (line_sw(i)) begin : g_sw
            assign we_i  = req_we;
            assign val_i = req_wval[i - XINT_SW_BASE];
         end else begin : g_nosw
            assign we_i  = 1'b0;
            assign val_i = 1'b0;
         end

         xint_edge #(
            .MODE (LMODE)
         ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (lvl_sync[i]),
            .pol_rise (pol_rise[line_pol_idx(i)]),
            .hit      (hit[i])
         );

         xint_flag #(
            .HAS_ACK (LACK)
         ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (hit[i]),
            .ack    (ack_i),
            .sw_we  (we_i),
            .sw_val (val_i),
            .flag   (irq_pend[i])
         );
      end
   endgenerate

   AST_L6_SW_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pend[NUM_LINES-1]) |->
         $past(sfr_wr && (sfr_addr == REQ_ADDR) && !sfr_wdata[L6_BIT])); // R7

   AST_PEND_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend[0]) |-> $past(hit[0])); // R4

endmodule

// File: tb/test_xint_flag_ctrl.sv
module test_xint_flag_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] src = 7'b1100000;
   logic [5:0] ack = '0;
   logic [7:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [6:0] pend;

   int checks = 0;
   int errors = 0;

   localparam logic [6:0] IDLE = 7'b1100000;

   always #10 clk = ~clk;   // 50 MHz

   xint_flag_ctrl i_xint_flag_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_src   (src),
      .irq_ack   (ack),
      .sfr_addr  (addr),
      .sfr_wr    (wr),
      .sfr_wdata (wdata),
      .sfr_rdata (rdata),
      .irq_pend  (pend)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      step(1);
      wr = 1'b0;
   endtask

   task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic clear_all();
      addr = 8'hC0; wdata = 8'h00; wr = 1'b1; ack = 6'h3F;
      step(1);
      wr = 1'b0; ack = '0;
   endtask

   // does a source transition in direction dir (1 = rising) set line k?
   function automatic bit expect_hit(input int k, input bit dir, input bit p2, input bit p3);
      case (k)
         0, 1:    return !dir;
         2:       return dir == p2;
         3:       return dir == p3;
         4:       return dir;
         default: return !dir;
      endcase
   endfunction

   function automatic string line_tag(input int k);
      if (k == 2 || k == 3) return "R3";
      if (k >= 5)           return "R5";
      return "R4";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      logic [6:0] expv;
      bit         start;

      step(2);
      rst_n = 1'b1;
      step(2);

      // R1 reset state
      chk("R1 pend", {1'b0, pend}, 8'h00);
      sfr_read(8'hC8, rd); chk("R1 pol reg", rd, 8'h00);
      sfr_read(8'hC0, rd); chk("R1 req reg", rd, 8'h00);

      // sweep every polarity setting, line and direction
      for (int p = 0; p < 4; p++) begin
         sfr_write(8'hC8, {1'b0, p[1], p[0], 5'b0});
         sfr_read(8'hC8, rd); chk("R3 pol readback", rd, {1'b0, p[1], p[0], 5'b0});
         for (int k = 0; k < 7; k++) begin
            for (int d = 0; d < 2; d++) begin
               start = (d == 0);
               src[k] = start;
               step(4);
               clear_all();
               chk("R8 cleared", {1'b0, pend}, 8'h00);
               src[k] = ~start;
               step(2);
               chk("R2 not yet", {1'b0, pend}, 8'h00);
               step(1);
               expv = expect_hit(k, d[0], p[0], p[1]) ? (7'd1 << k) : 7'd0;
               chk(line_tag(k), {1'b0, pend}, {1'b0, expv});
               if (expv != 0) begin
                  if (k < 6) begin
                     ack[k] = 1'b1;
                     step(1);
                     ack = '0;
                     chk("R6 ack clear", {1'b0, pend}, 8'h00);
                  end else begin
                     ack = 6'h3F;
                     step(1);
                     ack = '0;
                     chk("R7 ack ignored", {1'b0, pend}, 8'h40);
                     sfr_write(8'hC0, 8'h00);
                     chk("R7 sw clear", {1'b0, pend}, 8'h00);
                  end
               end
               src[k] = IDLE[k];
               step(4);
               clear_all();
            end
         end
      end

      sfr_write(8'hC8, 8'h00);

      // R10 edge versus acknowledge on line 4
      sfr_write(8'hC0, 8'h08);
      chk("R8 sw set line4", {1'b0, pend}, 8'h10);
      src[4] = 1'b1;
      step(2);
      ack[4] = 1'b1;
      step(1);
      ack = '0;
      chk("R10 edge beats ack", {1'b0, pend}, 8'h10);
      ack[4] = 1'b1;
      step(1);
      ack = '0;
      chk("R6 ack line4", {1'b0, pend}, 8'h00);
      src[4] = 1'b0;
      step(4);

      // R10 edge versus software clear
      sfr_write(8'hC0, 8'h08);
      src[4] = 1'b1;
      step(2);
      addr = 8'hC0; wdata = 8'h00; wr = 1'b1;
      step(1);
      wr = 1'b0;
      chk("R10 edge beats sw clear", {1'b0, pend}, 8'h10);
      sfr_write(8'hC0, 8'h00);
      src[4] = 1'b0;
      step(4);
      chk("R10 cleared after", {1'b0, pend}, 8'h00);

      // R11 software write versus acknowledge
      sfr_write(8'hC0, 8'h02);
      ack[2] = 1'b1; addr = 8'hC0; wdata = 8'h02; wr = 1'b1;
      step(1);
      ack = '0; wr = 1'b0;
      chk("R11 write 1 beats ack", {1'b0, pend}, 8'h04);
      ack[2] = 1'b1; addr = 8'hC0; wdata = 8'h00; wr = 1'b1;
      step(1);
      ack = '0; wr = 1'b0;
      chk("R11 write 0 with ack", {1'b0, pend}, 8'h00);

      // R8 request register layout
      sfr_write(8'hC0, 8'hFF);
      chk("R8 all set", {1'b0, pend}, 8'h7C);
      sfr_read(8'hC0, rd); chk("R8 spare bits zero", rd, 8'h3E);
      sfr_write(8'hC0, 8'h10);
      chk("R8 single bit line5", {1'b0, pend}, 8'h20);
      sfr_read(8'hC0, rd); chk("R8 readback line5", rd, 8'h10);
      sfr_write(8'hC0, 8'h3E);

      // R9 polarity register and foreign addresses
      sfr_write(8'hC8, 8'hFF);
      sfr_read(8'hC8, rd); chk("R9 pol spare", rd, 8'h60);
      sfr_write(8'hC8, 8'h9F);
      sfr_read(8'hC8, rd); chk("R9 pol cleared", rd, 8'h00);
      sfr_write(8'hC1, 8'h00);
      chk("R9 foreign write flags", {1'b0, pend}, 8'h7C);
      sfr_write(8'hC9, 8'hFF);
      sfr_read(8'hC8, rd); chk("R9 foreign write pol", rd, 8'h00);
      sfr_read(8'h00, rd); chk("R9 foreign read", rd, 8'h00);
      clear_all();
      chk("R7 final clear", {1'b0, pend}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule